// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Sequencer

This block sits on the target side of a serial flash link and tracks one fast-read transaction from chip-select assertion to release. It watches the serial clock level, finds its rising edges in the system clock domain, and steps through four phases: opcode, address, wait and data. Each phase moves 1, 2 or 4 bits per serial clock, depending on the read type the opcode selects. A separate four-lane mode carries the opcode on four lines as well.

The block reports the current phase and the number of active lines. It keeps a 21-bit byte address for a 2 MB array and presents that address to an external memory. It shifts the returned byte onto the data lines, most significant bits first. After each byte the address either steps linearly through the whole array, or stays inside an aligned window of 8, 16, 32 or 64 bytes for cached burst fills.

Top module: `mio_read_seq`

## Requirements
- R1: While `cs_n` is high the phase reads 0 (idle) one system clock later and `io_oe` is 0. Releasing `cs_n` in the middle of any phase ends the transaction, and the next assertion starts again with a fresh opcode.
- R2: Bits are captured only on rising edges of `sck` seen while `cs_n` is low. A transaction that starts with `sck` high (clock mode 3) behaves exactly like one that starts with it low (clock mode 0).
- R3: In normal mode the opcode takes 8 clocks on `io_in[0]`, MSB first. 0x0B selects 1 line, 0xBB selects 2 lines and 0xEB selects 4 lines. With `qpi_en` set, the opcode takes 2 clocks on `io_in[3:0]` (high nibble first), and only 0xEB is accepted. Any other opcode moves to the discard phase (5), where `io_oe` stays 0 until `cs_n` rises.
- R4: The address is 24 bits, MSB first, sent over 24, 12 or 6 clocks for 1, 2 or 4 lines. Its low 21 bits become `addr`, and the phase then reads 3 (wait).
- R5: The wait phase lasts 8 clocks for 1 line, 4 for 2 lines and 6 for 4 lines in normal mode. With `qpi_en` set it lasts 6 clocks if `qpi_dummy6` is 1, else 4. After the last wait clock the phase reads 4 (data).
- R6: In the data phase `io_oe` enables lines [w-1:0] for w lines. Each byte from `rd_data` is driven MSB first: bit groups go out on `io_out[w-1:0]` in 8/w clocks, with the higher bit on the higher line.
- R7: With `wrap_en` low, `addr` increases by one after each byte and wraps from 0x1FFFFF to 0.
- R8: With `wrap_en` high, the window length is 8 shifted left by `wrap_sel` (0:8, 1:16, 2:32, 3:64 bytes). The address steps inside that aligned window, and its bits above the window never change.
- R9: The phase codes are 0 idle, 1 opcode, 2 address, 3 wait, 4 data and 5 discard. `lanes` reads the lines per clock of the current phase (1, 2 or 4), and 0 in idle and discard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck | input | 1 | Serial clock level |
| cs_n | input | 1 | Active-low chip select |
| qpi_en | input | 1 | Four-lane opcode mode |
| qpi_dummy6 | input | 1 | Four-lane mode wait length: 1 = 6 clocks, 0 = 4 |
| wrap_en | input | 1 | Enable windowed burst addressing |
| wrap_sel | input | 2 | Window length select |
| io_in | input | 4 | Serial data lines in |
| rd_data | input | 8 | Array byte at `addr` |
| io_out | output | 4 | Serial data lines out |
| io_oe | output | 4 | Per-line output enable |
| phase | output | 3 | Current phase code |
| lanes | output | 3 | Lines per clock in the current phase |
| addr | output | 21 | Current byte address |

## Verification
The properties assume that every `sck` level lasts at least two system clocks, so that each rising edge is seen exactly once. They also assume that `cs_n` falls at least one system clock before the first rising edge, and that the mode and wrap inputs stay fixed while `cs_n` is low. The driver meets these assumptions: it changes `sck` and `io_in` only on falling `clk` edges, holds each serial level for two cycles, waits three cycles after selecting the device, and sets the configuration before `cs_n` falls. Expected bytes come from a computed memory function and are compared against what the driver collects from the data lines.

// File: rtl/mio_read_seq.sv
module mio_read_seq #(
  parameter int AW = 21,
  parameter int XW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sck,
  input  logic          cs_n,
  input  logic          qpi_en,
  input  logic          qpi_dummy6,
  input  logic          wrap_en,
  input  logic [1:0]    wrap_sel,
  input  logic [3:0]    io_in,
  input  logic [7:0]    rd_data,
  output logic [3:0]    io_out,
  output logic [3:0]    io_oe,
  output logic [2:0]    phase,
  output logic [2:0]    lanes,
  output logic [AW-1:0] addr
);
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0, PH_CMD = 3'd1, PH_ADDR = 3'd2,
    PH_WAIT = 3'd3, PH_DATA = 3'd4, PH_SKIP = 3'd5
  } ph_t;

  ph_t           ph;
  logic          sck_q;
  logic [2:0]    rw;
  logic [4:0]    cnt;
  logic [XW-1:0] sh;
  logic [AW-1:0] addr_q;

  wire rise = sck & ~sck_q & ~cs_n;
  wire [2:0] cmd_w = qpi_en ? 3'd4 : 3'd1;
  wire [2:0] cur_w = (ph == PH_CMD) ? cmd_w : rw;

  logic [XW-1:0] sh_nx;
  logic [4:0]    len;
  logic [2:0]    dec_w;
  logic [3:0]    lane_mask;

  always_comb begin
    case (cur_w)
      3'd2:    sh_nx = {sh[XW-3:0], io_in[1:0]};
      3'd4:    sh_nx = {sh[XW-5:0], io_in};
      default: sh_nx = {sh[XW-2:0], io_in[0]};
    endcase
    case (rw)
      3'd2:    lane_mask = 4'h3;
      3'd4:    lane_mask = 4'hF;
      default: lane_mask = 4'h1;
    endcase
    case (ph)
      PH_CMD:  len = qpi_en ? 5'd2 : 5'd8;
      PH_ADDR: len = (rw == 3'd4) ? 5'(XW / 4) : (rw == 3'd2) ? 5'(XW / 2) : 5'(XW);
      PH_WAIT: len = qpi_en ? (qpi_dummy6 ? 5'd6 : 5'd4)
                            : (rw == 3'd4) ? 5'd6 : (rw == 3'd2) ? 5'd4 : 5'd8;
      default: len = (rw == 3'd4) ? 5'd2 : (rw == 3'd2) ? 5'd4 : 5'd8;
    endcase
    if (qpi_en)
      dec_w = (sh_nx[7:0] == 8'hEB) ? 3'd4 : 3'd0;
    else
      case (sh_nx[7:0])
        8'h0B:   dec_w = 3'd1;
        8'hBB:   dec_w = 3'd2;
        8'hEB:   dec_w = 3'd4;
        default: dec_w = 3'd0;
      endcase
  end

  wire last = (cnt == len - 5'd1);

  wire [AW-1:0] win_mask = AW'((32'd8 << wrap_sel) - 32'd1);
  wire [AW-1:0] lin_nx   = addr_q + AW'(1);
  wire [AW-1:0] addr_nx  = wrap_en ? ((addr_q & ~win_mask) | (lin_nx & win_mask)) : lin_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= PH_IDLE; sck_q <= 1'b0; rw <= 3'd1; cnt <= '0; sh <= '0; addr_q <= '0;
    end else begin
      sck_q <= sck;
      if (cs_n) begin
        ph <= PH_IDLE; cnt <= '0;
      end else begin
        case (ph)
          PH_IDLE: begin ph <= PH_CMD; cnt <= '0; end
          PH_CMD: if (rise) begin
            sh <= sh_nx;
            if (last) begin
              cnt <= '0;
              if (dec_w != 3'd0) begin rw <= dec_w; ph <= PH_ADDR; end
              else ph <= PH_SKIP;
            end else cnt <= cnt + 5'd1;
          end
          PH_ADDR: if (rise) begin
            sh <= sh_nx;
            if (last) begin
              cnt <= '0; addr_q <= sh_nx[AW-1:0]; ph <= PH_WAIT;
            end else cnt <= cnt + 5'd1;
          end
          PH_WAIT: if (rise) begin
            if (last) begin cnt <= '0; ph <= PH_DATA; end
            else cnt <= cnt + 5'd1;
          end
          PH_DATA: if (rise) begin
            if (last) begin cnt <= '0; addr_q <= addr_nx; end
            else cnt <= cnt + 5'd1;
          end
          default: ;
        endcase
      end
    end
  end

  int sft;
  always_comb begin
    sft    = 8 - int'(rw) * (int'(cnt) + 1);
    io_out = (ph == PH_DATA) ? (4'(rd_data >> sft) & lane_mask) : 4'h0;
  end

  assign io_oe = (ph == PH_DATA) ? lane_mask : 4'h0;
  assign phase = ph;
  assign lanes = (ph == PH_IDLE || ph == PH_SKIP) ? 3'd0 : cur_w;
  assign addr  = addr_q;

  p_cs_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> ph == PH_IDLE);
  p_cmd_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_CMD |=> ph inside {PH_CMD, PH_ADDR, PH_SKIP, PH_IDLE});
  p_skip_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_SKIP |=> ph inside {PH_SKIP, PH_IDLE});
  p_addr_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_ADDR |=> ph inside {PH_ADDR, PH_WAIT, PH_IDLE});
  p_wait_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ph == PH_WAIT |=> ph inside {PH_WAIT, PH_DATA, PH_IDLE});
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA && !rise) |=> $stable(addr_q));
  p_wrap_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_DATA && wrap_en) |=> addr_q[AW-1:6] == $past(addr_q[AW-1:6]));
endmodule

// File: tb/mio_read_seq_tb_top.sv
module mio_read_seq_tb_top;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst_n = 0, sck = 0, cs_n = 1, qpi_en = 0, qpi_dummy6 = 0, wrap_en = 0;
  logic [1:0] wrap_sel = 0;
  logic [3:0] io_in = 0, io_out, io_oe;
  logic [7:0] rd_data;
  logic [2:0] phase, lanes;
  logic [20:0] addr;

  mio_read_seq dut_i (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .qpi_en(qpi_en),
    .qpi_dummy6(qpi_dummy6), .wrap_en(wrap_en), .wrap_sel(wrap_sel), .io_in(io_in),
    .rd_data(rd_data), .io_out(io_out), .io_oe(io_oe), .phase(phase), .lanes(lanes),
    .addr(addr));

  function automatic logic [7:0] mem_byte(logic [20:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ {3'b000, a[20:16]};
  endfunction
  assign rd_data = mem_byte(addr);

  int vectors = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk);
    while (rx_q.size() > 0 && exp_q.size() > 0) begin
      logic [7:0] g, e;
      g = rx_q.pop_front();
      e = exp_q.pop_front();
      check("R6 data byte", int'(g), int'(e));
    end
  end

  task automatic tick(input logic [3:0] din, output logic [3:0] dout);
    sck = 0; io_in = din;
    repeat (2) @(negedge clk);
    dout = io_out;
    sck = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [23:0] val, input int nbits, input int w);
    logic [3:0] d;
    for (int i = 0; i < nbits / w; i++)
      tick(4'((val >> (nbits - w * (i + 1))) & ((1 << w) - 1)), d);
  endtask

  function automatic logic [20:0] next_a(logic [20:0] a, bit wen, logic [1:0] ws);
    int win;
    logic [20:0] m;
    win = 8 << ws;
    m = 21'(win - 1);
    if (!wen) return a + 21'd1;
    return (a & ~m) | ((a + 21'd1) & m);
  endfunction

  task automatic finish_cs();
    sck = 0;
    @(negedge clk);
    cs_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", int'(phase), 0);
    check("R1 oe off after release", int'(io_oe), 0);
  endtask

  task automatic txn(bit qpi, bit d6, bit wen, logic [1:0] ws, logic [7:0] op,
                     logic [23:0] a, int nb, bit m3);
    int w, nd;
    logic [20:0] cur;
    logic [3:0] d;
    qpi_en = qpi; qpi_dummy6 = d6; wrap_en = wen; wrap_sel = ws;
    sck = m3; io_in = 0;
    @(negedge clk);
    cs_n = 0;
    repeat (3) @(negedge clk);
    check("R9 opcode phase code", int'(phase), 1);
    check("R9 opcode lanes", int'(lanes), qpi ? 4 : 1);
    send({16'h0, op}, 8, qpi ? 4 : 1);
    if (qpi) w = (op == 8'hEB) ? 4 : 0;
    else w = (op == 8'h0B) ? 1 : (op == 8'hBB) ? 2 : (op == 8'hEB) ? 4 : 0;
    if (w == 0) begin
      check("R3 discard phase", int'(phase), 5);
      for (int k = 0; k < 12; k++) tick(4'hF, d);
      check("R3 discard keeps lines off", int'(io_oe), 0);
      check("R3 discard phase held", int'(phase), 5);
      finish_cs();
      return;
    end
    check("R3 address phase", int'(phase), 2);
    check("R9 address lanes", int'(lanes), w);
    send(a, 24, w);
    check("R4 wait phase", int'(phase), 3);
    check("R4 address captured", int'(addr), int'(a[20:0]));
    nd = qpi ? (d6 ? 6 : 4) : (w == 1 ? 8 : (w == 2 ? 4 : 6));
    for (int k = 0; k < nd; k++) begin
      tick(4'h0, d);
      check("R5 wait length", int'(phase), (k == nd - 1) ? 4 : 3);
    end
    check("R6 output enable", int'(io_oe), (1 << w) - 1);
    cur = a[20:0];
    for (int b = 0; b < nb; b++) begin
      logic [7:0] rx;
      exp_q.push_back(mem_byte(cur));
      rx = 0;
      for (int s = 0; s < 8 / w; s++) begin
        tick(4'h0, d);
        rx = 8'((rx << w) | (d & 4'((1 << w) - 1)));
      end
      rx_q.push_back(rx);
      cur = next_a(cur, wen, ws);
    end
    if (wen) check("R8 windowed address", int'(addr), int'(cur));
    else check("R7 linear address", int'(addr), int'(cur));
    finish_cs();
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset phase", int'(phase), 0);
    check("R1 reset oe", int'(io_oe), 0);
    check("R9 reset lanes", int'(lanes), 0);

    txn(0, 0, 0, 0, 8'h0B, 24'h001234, 4, 0);
    txn(0, 0, 0, 0, 8'hBB, 24'h0ABCDE, 3, 0);
    txn(0, 0, 0, 0, 8'hEB, 24'hFFFFFE, 4, 0);   // R7 wrap to zero, upper bits dropped
    txn(1, 0, 1, 2'd0, 8'hEB, 24'h000105, 6, 0); // R8 8-byte window
    txn(1, 1, 1, 2'd3, 8'hEB, 24'h00013E, 4, 0); // R8 64-byte window
    txn(0, 0, 1, 2'd1, 8'hEB, 24'h00002F, 3, 0); // R8 16-byte window
    txn(0, 0, 0, 0, 8'h0B, 24'h100077, 2, 1);   // R2 clock idles high
    txn(0, 0, 0, 0, 8'h9F, 24'h0, 0, 0);        // R3 unknown opcode
    txn(1, 0, 0, 0, 8'h0B, 24'h0, 0, 0);        // R3 only 0xEB in four-lane mode

    begin
      logic [3:0] d;
      qpi_en = 0; sck = 0;
      @(negedge clk);
      cs_n = 0;
      repeat (3) @(negedge clk);
      send(24'h00000B, 8, 1);
      for (int k = 0; k < 10; k++) tick(4'h1, d);
      check("R1 mid-address still in address", int'(phase), 2);
      finish_cs();
    end
    txn(0, 0, 0, 0, 8'hBB, 24'h000400, 2, 0);   // R1 fresh start after abort

    repeat (6) @(negedge clk);
    check("R6 all bytes compared", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule